// File: doc/BRIEF.md
# Command Descriptor Length Decoder

This block sits beside the transfer engine of a SCSI-style controller. When a block move is issued while the controller acts as target and the move's phase field selects the command phase, the decoder watches for the first received command byte. It takes the group code from the top three bits of that byte. From the group code it decides whether the programmed 24-bit transfer count is replaced by the standard command-block length, and it presents the count the engine should then use.

A configuration input decides how the two vendor-unique groups are handled. They either follow the standard length table or keep the programmed count. When the programmed count is kept and it is zero, no usable length exists, so the block raises a one-cycle illegal-instruction interrupt instead.

Top module: `cdb_len_decoder`

## Requirements
- R1: In the cycle after `start_i`, `count_o` equals the `prog_count_i` value sampled with `start_i`, and both `overwritten_o` and `illegal_irq_o` are 0. `start_i` takes priority over a byte strobe in the same cycle.
- R2: Decoding is armed only if `target_mode_i` and `cmd_phase_i` are both 1 when `start_i` is sampled. When it is not armed, byte strobes change neither the count nor any flag.
- R3: The group code is bits 7:5 of `byte_i`. For groups 0, 1, 2 and 5, `count_o` becomes 6, 10, 10 and 12 respectively, and `overwritten_o` is set, in the cycle after the strobe.
- R4: With `vu_keep_count_i` = 0, vendor-unique group 6 overwrites the count with 6 and group 7 overwrites it with 12, and `overwritten_o` is set.
- R5: With `vu_keep_count_i` = 1, groups 6 and 7 leave `count_o` at the programmed value, and `overwritten_o` stays 0.
- R6: Groups 3 and 4 leave `count_o` at the programmed value, and `overwritten_o` stays 0.
- R7: When the count is left unchanged and it is zero, `illegal_irq_o` pulses high for exactly one cycle, in the cycle after the strobe. It is never high together with `overwritten_o`.
- R8: Only the first strobed byte after `start_i` is decoded. Later bytes change neither the count nor any flag.
- R9: `count_o` holds its value in every cycle without `start_i` or an accepted first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | A block move is issued; loads the count and arms the decode |
| target_mode_i | input | 1 | The controller acts as target |
| cmd_phase_i | input | 1 | The move's phase field selects the command phase |
| vu_keep_count_i | input | 1 | 1: vendor-unique groups keep the programmed count |
| prog_count_i | input | 24 | Programmed transfer count |
| byte_valid_i | input | 1 | A received command byte is present |
| byte_i | input | 8 | Received command byte |
| count_o | output | 24 | Effective transfer count |
| overwritten_o | output | 1 | The count was replaced from the group table |
| illegal_irq_o | output | 1 | One-cycle illegal-instruction interrupt |

## Verification
The bench walks every group code, in both settings of the vendor-unique bit. A wrong table entry, or a mix-up of groups 6 and 7, would show up as the wrong length on `count_o`. Zero programmed counts are paired with kept groups to show that the interrupt is exactly one cycle long, and with table groups to show that an overwritten zero raises no interrupt. A second byte is sent after the first, so a design that decoded every strobe would change the count again. Strobes are also sent in a non-command phase and in initiator mode, where a design that did not gate the decode would overwrite a count it must leave alone.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned GRP_W    = 3;
  localparam int unsigned GRP_LSB  = BYTE_W - GRP_W;
  localparam int unsigned LEN_SHORT = 6;
  localparam int unsigned LEN_MID   = 10;
  localparam int unsigned LEN_LONG  = 12;

  typedef enum logic [GRP_W-1:0] {
    GRP_0 = 3'd0, GRP_1 = 3'd1, GRP_2 = 3'd2, GRP_3 = 3'd3,
    GRP_4 = 3'd4, GRP_5 = 3'd5, GRP_VU6 = 3'd6, GRP_VU7 = 3'd7
  } grp_e;
endpackage

// File: rtl/cdb_group_decode.sv
module cdb_group_decode
  import cdb_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              vu_keep_i,
  output logic              hit_o,
  output logic [CNT_W-1:0]  len_o
);
  grp_e grp;
  assign grp = grp_e'(byte_i[BYTE_W-1:GRP_LSB]);

  always_comb begin
    hit_o = 1'b1;
    len_o = CNT_W'(LEN_SHORT);
    unique case (grp)
      GRP_0:   len_o = CNT_W'(LEN_SHORT);
      GRP_1,
      GRP_2:   len_o = CNT_W'(LEN_MID);
      GRP_5:   len_o = CNT_W'(LEN_LONG);
      GRP_VU6: begin hit_o = !vu_keep_i; len_o = CNT_W'(LEN_SHORT); end
      GRP_VU7: begin hit_o = !vu_keep_i; len_o = CNT_W'(LEN_LONG);  end
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cdb_count_ctrl.sv
module cdb_count_ctrl #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] prog_count_i,
  input  logic             byte_valid_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] count_o,
  output logic             overwritten_o,
  output logic             illegal_irq_o
);
  logic armed_q, take;

  assign take = armed_q && byte_valid_i && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q       <= 1'b0;
      count_o       <= '0;
      overwritten_o <= 1'b0;
      illegal_irq_o <= 1'b0;
    end else begin
      illegal_irq_o <= 1'b0;
      if (start_i) begin
        armed_q       <= arm_i;
        count_o       <= prog_count_i;
        overwritten_o <= 1'b0;
      end else if (take) begin
        armed_q <= 1'b0;  // first byte only
        if (hit_i) begin
          count_o       <= len_i;
          overwritten_o <= 1'b1;
        end else begin
          illegal_irq_o <= (count_o == '0);
        end
      end
    end
  end
endmodule

// File: rtl/cdb_len_decoder.sv
module cdb_len_decoder
  import cdb_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              target_mode_i,
  input  logic              cmd_phase_i,
  input  logic              vu_keep_count_i,
  input  logic [CNT_W-1:0]  prog_count_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              overwritten_o,
  output logic              illegal_irq_o
);
  logic             hit;
  logic [CNT_W-1:0] len;

  cdb_group_decode #(.CNT_W(CNT_W)) u_dec (
    .byte_i    (byte_i),
    .vu_keep_i (vu_keep_count_i),
    .hit_o     (hit),
    .len_o     (len)
  );

  cdb_count_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .arm_i         (target_mode_i && cmd_phase_i),
    .prog_count_i  (prog_count_i),
    .byte_valid_i  (byte_valid_i),
    .hit_i         (hit),
    .len_i         (len),
    .count_o       (count_o),
    .overwritten_o (overwritten_o),
    .illegal_irq_o (illegal_irq_o)
  );
endmodule

// File: rtl/cdb_len_decoder_chk.sv
module cdb_len_decoder_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             byte_valid_i,
  input logic [CNT_W-1:0] prog_count_i,
  input logic [CNT_W-1:0] count_o,
  input logic             overwritten_o,
  input logic             illegal_irq_o
);
  AST_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (count_o == $past(prog_count_i)) && !overwritten_o && !illegal_irq_o); // R1
  AST_OVW_NEEDS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overwritten_o) |-> $past(byte_valid_i) && !$past(start_i)); // R3
  AST_OVW_LEN_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overwritten_o |-> (count_o == CNT_W'(6) || count_o == CNT_W'(10) || count_o == CNT_W'(12))); // R4
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_irq_o |=> !illegal_irq_o); // R7
  AST_IRQ_ZERO_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_irq_o |-> (count_o == '0) && !overwritten_o); // R7
  AST_COUNT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !byte_valid_i) |=> $stable(count_o)); // R9
endmodule

bind cdb_len_decoder cdb_len_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .byte_valid_i  (byte_valid_i),
  .prog_count_i  (prog_count_i),
  .count_o       (count_o),
  .overwritten_o (overwritten_o),
  .illegal_irq_o (illegal_irq_o)
);

// File: tb/cdb_len_decoder_tb_top.sv
module cdb_len_decoder_tb_top;
  localparam int unsigned CW = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0, target_mode_i = 1'b0, cmd_phase_i = 1'b0;
  logic          vu_keep_count_i = 1'b0, byte_valid_i = 1'b0;
  logic [CW-1:0] prog_count_i = '0;
  logic [7:0]    byte_i = '0;
  logic [CW-1:0] count_o;
  logic          overwritten_o, illegal_irq_o;

  int n_run = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  cdb_len_decoder dut_i (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_start(input int cnt, input bit tm, input bit cp, input bit vu);
    @(negedge clk_i);
    start_i = 1'b1; prog_count_i = CW'(cnt);
    target_mode_i = tm; cmd_phase_i = cp; vu_keep_count_i = vu;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // drive one byte, return at the negedge after the update edge
  task automatic send_byte(input logic [7:0] b);
    byte_valid_i = 1'b1; byte_i = b;
    @(negedge clk_i);
    byte_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "reset count", int'(count_o), 0);
    check("R1", "reset ovw", int'(overwritten_o), 0);
    check("R1", "reset irq", int'(illegal_irq_o), 0);
  endtask

  task automatic t_table(input int grp, input bit vu, input int exp_len, input string req);
    do_start(100, 1, 1, vu);
    check("R1", "count after start", int'(count_o), 100);
    send_byte(8'(grp << 5) | 8'h0A);
    check(req, $sformatf("count grp%0d vu%0d", grp, vu), int'(count_o), exp_len);
    check(req, $sformatf("ovw grp%0d vu%0d", grp, vu), int'(overwritten_o), exp_len != 100);
    check(req, "no irq", int'(illegal_irq_o), 0);
  endtask

  task automatic t_zero_kept(input int grp, input bit vu, input string req);
    do_start(0, 1, 1, vu);
    send_byte(8'(grp << 5));
    check(req, $sformatf("irq grp%0d", grp), int'(illegal_irq_o), 1);
    check(req, "ovw with irq", int'(overwritten_o), 0);
    @(negedge clk_i);
    check("R7", "irq one cycle", int'(illegal_irq_o), 0);
  endtask

  task automatic t_zero_overwritten;
    do_start(0, 1, 1, 0);
    send_byte(8'hA0);  // group 5
    check("R7", "no irq on overwrite", int'(illegal_irq_o), 0);
    check("R3", "zero count overwritten", int'(count_o), 12);
  endtask

  task automatic t_not_armed(input bit tm, input bit cp);
    do_start(0, tm, cp, 0);
    send_byte(8'h00);
    check("R2", "count unarmed", int'(count_o), 0);
    check("R2", "ovw unarmed", int'(overwritten_o), 0);
    check("R2", "irq unarmed", int'(illegal_irq_o), 0);
  endtask

  task automatic t_second_byte;
    do_start(77, 1, 1, 0);
    send_byte(8'h20);  // group 1
    check("R8", "first byte", int'(count_o), 10);
    send_byte(8'hA0);  // group 5 must be ignored
    check("R8", "second byte ignored", int'(count_o), 10);
    do_start(0, 1, 1, 1);
    send_byte(8'h60);  // group 3, zero -> irq
    @(negedge clk_i);
    send_byte(8'h60);
    check("R8", "no second irq", int'(illegal_irq_o), 0);
  endtask

  task automatic t_hold_and_priority;
    do_start(55, 1, 1, 0);
    repeat (3) @(negedge clk_i);
    check("R9", "count holds", int'(count_o), 55);
    // start and byte together: start wins, decode stays armed
    start_i = 1'b1; prog_count_i = CW'(33); byte_valid_i = 1'b1; byte_i = 8'h00;
    @(negedge clk_i);
    start_i = 1'b0; byte_valid_i = 1'b0;
    check("R1", "start priority count", int'(count_o), 33);
    check("R1", "start priority ovw", int'(overwritten_o), 0);
    send_byte(8'h00);
    check("R1", "still armed", int'(count_o), 6);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_table(0, 0, 6,  "R3");
    t_table(1, 0, 10, "R3");
    t_table(2, 1, 10, "R3");
    t_table(5, 1, 12, "R3");
    t_table(6, 0, 6,  "R4");
    t_table(7, 0, 12, "R4");
    t_table(6, 1, 100, "R5");
    t_table(7, 1, 100, "R5");
    t_table(3, 0, 100, "R6");
    t_table(4, 0, 100, "R6");
    t_zero_kept(3, 0, "R7");
    t_zero_kept(4, 1, "R7");
    t_zero_kept(7, 1, "R5");
    t_zero_overwritten();
    t_not_armed(1, 0);
    t_not_armed(0, 1);
    t_second_byte();
    t_hold_and_priority();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule